// File: doc/BRIEF.md
# Set-Associative Data Cache with Per-Half Dirty Tracking

This block is a set-associative data cache controller. It sits between a load/store requester and a word-wide memory port. Each request carries an operation code, a 32-bit byte address and, for stores, a data word. The address splits into a tag, a set index, a word offset and two byte bits. A lookup compares the tag against every way of the indexed set.

When a line must be allocated, the victim way is chosen by a rotating counter that each set keeps for itself. Each line holds a valid flag and two dirty flags, one for its first half and one for its last half. Eviction and clean therefore send only the modified halves back to memory. A mode input selects the store policy per request: write-back or write-through. Maintenance requests clean a line, invalidate a line, or invalidate the whole cache. Each line keeps the tag it was filled from, so its memory address can be rebuilt when it is written back.

Top module: `set_assoc_cache`

## Requirements
- R1: With default parameters, address bits [1:0] are byte bits and are ignored, bits [4:2] select the word, bits [10:5] select the set, and bits [31:11] form the tag. Two addresses that differ only in the byte bits hit the same word.
- R2: A read (reqOp = 0) that misses fetches the whole line with word reads and returns the requested word with respHit = 0. A later read of the same line hits (respHit = 1) and returns the cached word. While memReq is high and memAck is low, memAddr stays constant.
- R3: Each set has a way counter that resets to 0 and advances by one, modulo the way count, on every allocation in that set. The counter picks the victim way whether or not that way is valid.
- R4: Before a refill, a valid victim writes back only its dirty halves, each half being 4 words. A victim with no dirty half causes no memory write.
- R5: In write-back mode (wbMode = 1), a store (reqOp = 1) that hits updates the cached word and makes no memory access. It sets status bit 1 when the word index is below 4, or status bit 2 when the index is 4 or above.
- R6: In write-through mode (wbMode = 0), a store updates the cached word and writes that word to memory exactly once. It never sets a dirty flag.
- R7: A store that misses first allocates and fills the line, then applies the store under the current mode.
- R8: Clean (reqOp = 2) writes back the dirty halves of a line that hits and then clears both dirty flags. The line stays valid, and respHit reports whether the line was present. A clean line produces no memory traffic.
- R9: Invalidate by address (reqOp = 3) clears the valid flag of a line that hits, without writing back. respHit reports presence, and a later access to that line misses.
- R10: Invalidate all (reqOp = 4) clears every line's status in one step, discarding dirty data. It responds with respHit = 0.
- R11: Reset clears every line status and every way counter. After reset, reqReady = 1, respValid = 0 and memReq = 0.
- R12: Every accepted request ends with respValid high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wbMode | input | 1 | 1 = write-back, 0 = write-through; sampled when a request is accepted |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqOp | input | 3 | 0 read, 1 write, 2 clean, 3 invalidate line, 4 invalidate all |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Store data |
| reqReady | output | 1 | Controller idle and able to take a request |
| respValid | output | 1 | One-cycle completion pulse |
| respData | output | 32 | Read data (zero for other operations) |
| respHit | output | 1 | Line was present at lookup |
| memReq | output | 1 | Memory word access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | One-cycle acknowledge per word |

## Verification
Some properties are checked by assertions on every cycle:
- a memory address is held until it is acknowledged;
- eviction only ever drives words from a half whose dirty flag is set;
- an allocation advances the set's way counter by exactly one;
- a write-through store leaves the dirty flags unchanged;
- a finished write-back leaves the line valid and clean;
- invalidation leaves the address missing, and invalidate all leaves no valid line;
- the response is a single-cycle pulse.

Other behaviour needs the bench's scenarios. These include which way the rotation evicts, whether data written back by eviction or clean reaches memory and returns on a later refill, the number of words each eviction writes, and the loss of dirty data after an invalidation.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_CLEAN     = 3'd2,
    OP_INVAL     = 3'd3,
    OP_INVAL_ALL = 3'd4
  } cacheOp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_FINISH,
    ST_WTWRITE
  } ctrlState_t;

  // Strobes from control to datapath, at most a few active in one cycle
  typedef struct packed {
    logic fillWord;
    logic writeWord;
    logic markDirty;
    logic clearDirty;
    logic allocLine;
    logic dropLine;
    logic dropAll;
  } dpStrobe_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 21,
  parameter int DATA_W = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SET_W-1:0]  setIdx,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [WORD_W-1:0] reqWord,
  input  logic [WAY_W-1:0]  way,
  input  logic [WORD_W-1:0] fillIdx,
  input  logic [DATA_W-1:0] fillData,
  input  logic [DATA_W-1:0] wrData,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic [2:0]        selStatus,
  output logic [TAG_W-1:0]  selTag,
  output logic [DATA_W-1:0] lineWord,
  output logic [DATA_W-1:0] readWord
);

  localparam int LINE_W = WAY_W + SET_W;
  localparam int LINES  = 1 << LINE_W;
  localparam int CELLS  = LINES * WORDS;

  logic [DATA_W-1:0] dataMem [CELLS];
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [2:0]        statMem [LINES];   // [0] valid, [1] first half dirty, [2] last half dirty
  logic [WAY_W-1:0]  rrCnt   [SETS];

  logic [LINE_W-1:0] selLine;
  logic [WAYS-1:0]   wayHit;
  logic [WAY_W-1:0]  rrCur;
  logic              anyValid;

  assign selLine = {way, setIdx};

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    localparam logic [WAY_W-1:0] WAY_ID = WAY_W'(g);
    assign wayHit[g] = statMem[{WAY_ID, setIdx}][0] && (tagMem[{WAY_ID, setIdx}] == tagIn);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayHit[w]) hitWay = WAY_W'(w);
    end
  end

  always_comb begin
    anyValid = 1'b0;
    for (int i = 0; i < LINES; i++) anyValid = anyValid | statMem[i][0];
  end

  assign hit       = |wayHit;
  assign rrCur     = rrCnt[setIdx];
  assign victimWay = rrCur;
  assign selStatus = statMem[selLine];
  assign selTag    = tagMem[selLine];
  assign lineWord  = dataMem[{way, setIdx, fillIdx}];
  assign readWord  = dataMem[{hitWay, setIdx, reqWord}];

  // Status and rotation counters: cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) statMem[i] <= 3'b000;
      for (int s = 0; s < SETS; s++) rrCnt[s] <= '0;
    end else if (strobe.dropAll) begin
      for (int i = 0; i < LINES; i++) statMem[i] <= 3'b000;
    end else begin
      if (strobe.allocLine) begin
        statMem[selLine] <= 3'b001;
        rrCnt[setIdx]    <= rrCur + 1'b1;
      end else if (strobe.dropLine) begin
        statMem[selLine] <= 3'b000;
      end else if (strobe.clearDirty) begin
        statMem[selLine] <= {2'b00, selStatus[0]};
      end else if (strobe.writeWord && strobe.markDirty) begin
        if (reqWord[WORD_W-1]) statMem[selLine][2] <= 1'b1;
        else                   statMem[selLine][1] <= 1'b1;
      end
    end
  end

  // Tag and data arrays carry no reset
  always_ff @(posedge clk) begin
    if (strobe.allocLine) tagMem[selLine] <= tagIn;
    if (strobe.fillWord)  dataMem[{way, setIdx, fillIdx}] <= fillData;
    if (strobe.writeWord) dataMem[{way, setIdx, reqWord}] <= wrData;
  end

  // R3
  rr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocLine |=> rrCur == $past(rrCur) + 1'b1);

  // R6
  wt_no_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeWord && !strobe.markDirty) |=> selStatus[2:1] == $past(selStatus[2:1]));

  // R8
  clean_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearDirty |=> (selStatus[0] == $past(selStatus[0])) && (selStatus[2:1] == 2'b00));

  // R9
  drop_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropLine |=> !hit);

  // R10
  drop_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropAll |=> !anyValid);

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int WORDS  = 8,
  parameter int SET_W  = 6,
  parameter int TAG_W  = 21,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int HALF   = WORDS / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbMode,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              respHit,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  output dpStrobe_t         strobe,
  output logic [SET_W-1:0]  setIdx,
  output logic [TAG_W-1:0]  tagOut,
  output logic [WORD_W-1:0] reqWord,
  output logic [WAY_W-1:0]  curWay,
  output logic [WORD_W-1:0] fillIdx,
  output logic [DATA_W-1:0] wrData,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hitWay,
  input  logic [WAY_W-1:0]  victimWay,
  input  logic [2:0]        selStatus,
  input  logic [TAG_W-1:0]  selTag,
  input  logic [DATA_W-1:0] lineWord,
  input  logic [DATA_W-1:0] readWord
);

  localparam logic [WORD_W-1:0] LAST_IDX  = WORD_W'(WORDS - 1);
  localparam logic [WORD_W-1:0] HALF_LAST = WORD_W'(HALF - 1);
  localparam logic [WORD_W-1:0] HALF_IDX  = WORD_W'(HALF);

  ctrlState_t               state;
  cacheOp_t                 opQ;
  logic [ADDR_W-1:BYTE_W]   addrQ;
  logic [DATA_W-1:0]        wdataQ;
  logic                     wbQ;
  logic                     hitQ;
  logic [WAY_W-1:0]         wayQ;
  logic [WORD_W-1:0]        idx;
  logic                     evictLast;
  logic                     needEvict;
  logic [WORD_W-1:0]        evictStart;
  logic                     unusedByteBits;

  assign unusedByteBits = ^reqAddr[BYTE_W-1:0];

  assign reqWord = addrQ[BYTE_W +: WORD_W];
  assign setIdx  = addrQ[BYTE_W + WORD_W +: SET_W];
  assign tagOut  = addrQ[ADDR_W-1 -: TAG_W];
  assign wrData  = wdataQ;
  assign fillIdx = idx;

  assign reqReady   = (state == ST_IDLE);
  assign needEvict  = selStatus[0] && (selStatus[2:1] != 2'b00);
  assign evictStart = selStatus[1] ? '0 : HALF_IDX;
  assign evictLast  = (idx == LAST_IDX) || ((idx == HALF_LAST) && !selStatus[2]);

  always_comb begin
    curWay = (state == ST_LOOKUP) ? (hit ? hitWay : victimWay) : wayQ;
  end

  // Memory port
  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memWdata = '0;
    case (state)
      ST_EVICT: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        memAddr  = {selTag, setIdx, idx, {BYTE_W{1'b0}}};
        memWdata = lineWord;
      end
      ST_FILL: begin
        memReq  = 1'b1;
        memAddr = {tagOut, setIdx, idx, {BYTE_W{1'b0}}};
      end
      ST_WTWRITE: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        memAddr  = {addrQ, {BYTE_W{1'b0}}};
        memWdata = wdataQ;
      end
      default: ;
    endcase
  end

  // Datapath strobes
  always_comb begin
    strobe = '0;
    case (state)
      ST_LOOKUP: begin
        case (opQ)
          OP_WRITE: if (hit) begin
            strobe.writeWord = 1'b1;
            strobe.markDirty = wbQ;
          end
          OP_INVAL:     strobe.dropLine = hit;
          OP_INVAL_ALL: strobe.dropAll  = 1'b1;
          default: ;
        endcase
      end
      ST_EVICT: strobe.clearDirty = memAck && evictLast;
      ST_FILL: begin
        strobe.fillWord  = memAck;
        strobe.allocLine = memAck && (idx == LAST_IDX);
      end
      ST_FINISH: begin
        strobe.writeWord = (opQ == OP_WRITE);
        strobe.markDirty = (opQ == OP_WRITE) && wbQ;
      end
      default: ;
    endcase
  end

  // Sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opQ       <= OP_READ;
      addrQ     <= '0;
      wdataQ    <= '0;
      wbQ       <= 1'b0;
      hitQ      <= 1'b0;
      wayQ      <= '0;
      idx       <= '0;
      respValid <= 1'b0;
      respData  <= '0;
      respHit   <= 1'b0;
    end else begin
      respValid <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          opQ    <= cacheOp_t'(reqOp);
          addrQ  <= reqAddr[ADDR_W-1:BYTE_W];
          wdataQ <= reqWdata;
          wbQ    <= wbMode;
          state  <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          wayQ <= curWay;
          hitQ <= hit;
          if ((opQ == OP_READ || opQ == OP_WRITE) && !hit) begin
            if (needEvict) begin
              idx   <= evictStart;
              state <= ST_EVICT;
            end else begin
              idx   <= '0;
              state <= ST_FILL;
            end
          end else if (opQ == OP_WRITE && !wbQ) begin
            state <= ST_WTWRITE;
          end else if (opQ == OP_CLEAN && hit && needEvict) begin
            idx   <= evictStart;
            state <= ST_EVICT;
          end else begin
            respValid <= 1'b1;
            respData  <= (opQ == OP_READ) ? readWord : '0;
            respHit   <= hit && (opQ != OP_INVAL_ALL);
            state     <= ST_IDLE;
          end
        end
        ST_EVICT: if (memAck) begin
          if (evictLast) begin
            if (opQ == OP_CLEAN) begin
              respValid <= 1'b1;
              respData  <= '0;
              respHit   <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              idx   <= '0;
              state <= ST_FILL;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_FILL: if (memAck) begin
          if (idx == LAST_IDX) state <= ST_FINISH;
          else                 idx   <= idx + 1'b1;
        end
        ST_FINISH: begin
          if (opQ == OP_WRITE && !wbQ) begin
            state <= ST_WTWRITE;
          end else begin
            respValid <= 1'b1;
            respData  <= (opQ == OP_READ) ? readWord : '0;
            respHit   <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_WTWRITE: if (memAck) begin
          respValid <= 1'b1;
          respData  <= '0;
          respHit   <= hitQ;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr));

  // R4
  evict_dirty_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVICT) |-> ((idx >= HALF_IDX) ? selStatus[2] : selStatus[1]));

  // R12
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

endmodule

// File: rtl/set_assoc_cache.sv
module set_assoc_cache
  import cache_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbMode,
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        reqReady,
  output logic        respValid,
  output logic [31:0] respData,
  output logic        respHit,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck
);

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WORD_W = $clog2(WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W - BYTE_W;

  dpStrobe_t         strobe;
  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagOut;
  logic [WORD_W-1:0] reqWord;
  logic [WAY_W-1:0]  curWay;
  logic [WORD_W-1:0] fillIdx;
  logic [DATA_W-1:0] wrData;
  logic              hit;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  victimWay;
  logic [2:0]        selStatus;
  logic [TAG_W-1:0]  selTag;
  logic [DATA_W-1:0] lineWord;
  logic [DATA_W-1:0] readWord;

  cache_control #(
    .WAYS(WAYS), .WORDS(WORDS), .SET_W(SET_W), .TAG_W(TAG_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .wbMode(wbMode),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .respValid(respValid), .respData(respData), .respHit(respHit),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .strobe(strobe), .setIdx(setIdx), .tagOut(tagOut), .reqWord(reqWord),
    .curWay(curWay), .fillIdx(fillIdx), .wrData(wrData),
    .hit(hit), .hitWay(hitWay), .victimWay(victimWay), .selStatus(selStatus),
    .selTag(selTag), .lineWord(lineWord), .readWord(readWord)
  );

  cache_datapath #(
    .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setIdx(setIdx), .tagIn(tagOut),
    .reqWord(reqWord), .way(curWay), .fillIdx(fillIdx), .fillData(memRdata),
    .wrData(wrData), .hit(hit), .hitWay(hitWay), .victimWay(victimWay),
    .selStatus(selStatus), .selTag(selTag), .lineWord(lineWord), .readWord(readWord)
  );

endmodule

// File: tb/test_set_assoc_cache.sv
`timescale 1ns/1ps
module test_set_assoc_cache;

  localparam logic [2:0] RD = 3'd0, WR = 3'd1, CL = 3'd2, IV = 3'd3, IA = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic        wb;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        expHit;
    logic        chkData;
    logic [31:0] expData;
    logic [7:0]  expWr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 26;
  // Set 1 lines: A=0x0020 B=0x0820 C=0x1020 D=0x1820 E=0x2020; untouched memory = addr ^ 0x5A5A0000
  localparam vec_t VECS [NV] = '{
    '{RD, 1'b1, 32'h0020, 32'h0,        1'b0, 1'b1, 32'h5A5A0020, 8'd0, 4'd2},  // R2 miss, way0
    '{RD, 1'b1, 32'h0024, 32'h0,        1'b1, 1'b1, 32'h5A5A0024, 8'd0, 4'd2},  // R2 hit
    '{WR, 1'b1, 32'h0024, 32'h11111111, 1'b1, 1'b0, 32'h0,        8'd0, 4'd5},  // R5 first half dirty
    '{RD, 1'b1, 32'h0024, 32'h0,        1'b1, 1'b1, 32'h11111111, 8'd0, 4'd5},
    '{RD, 1'b1, 32'h0820, 32'h0,        1'b0, 1'b1, 32'h5A5A0820, 8'd0, 4'd3},  // R3 way1
    '{RD, 1'b1, 32'h1020, 32'h0,        1'b0, 1'b1, 32'h5A5A1020, 8'd0, 4'd3},  // way2
    '{RD, 1'b1, 32'h1820, 32'h0,        1'b0, 1'b1, 32'h5A5A1820, 8'd0, 4'd3},  // way3
    '{RD, 1'b1, 32'h2020, 32'h0,        1'b0, 1'b1, 32'h5A5A2020, 8'd4, 4'd4},  // R4 evicts A: one half
    '{RD, 1'b1, 32'h0024, 32'h0,        1'b0, 1'b1, 32'h11111111, 8'd0, 4'd4},  // evicts clean B
    '{WR, 1'b1, 32'h003C, 32'h22222222, 1'b1, 1'b0, 32'h0,        8'd0, 4'd5},  // last half dirty
    '{WR, 1'b1, 32'h0020, 32'h33333333, 1'b1, 1'b0, 32'h0,        8'd0, 4'd5},
    '{CL, 1'b1, 32'h0020, 32'h0,        1'b1, 1'b0, 32'h0,        8'd8, 4'd8},  // R8 both halves
    '{CL, 1'b1, 32'h0020, 32'h0,        1'b1, 1'b0, 32'h0,        8'd0, 4'd8},  // already clean
    '{RD, 1'b1, 32'h003C, 32'h0,        1'b1, 1'b1, 32'h22222222, 8'd0, 4'd8},  // still valid
    '{WR, 1'b0, 32'h0028, 32'h44444444, 1'b1, 1'b0, 32'h0,        8'd1, 4'd6},  // R6
    '{CL, 1'b1, 32'h0028, 32'h0,        1'b1, 1'b0, 32'h0,        8'd0, 4'd6},  // no dirty set
    '{IV, 1'b1, 32'h0020, 32'h0,        1'b1, 1'b0, 32'h0,        8'd0, 4'd9},  // R9
    '{RD, 1'b1, 32'h0028, 32'h0,        1'b0, 1'b1, 32'h44444444, 8'd0, 4'd9},
    '{WR, 1'b1, 32'h2030, 32'h55555555, 1'b1, 1'b0, 32'h0,        8'd0, 4'd5},
    '{WR, 1'b0, 32'h3040, 32'h66666666, 1'b0, 1'b0, 32'h0,        8'd1, 4'd7},  // R7 set2 miss
    '{RD, 1'b1, 32'h3040, 32'h0,        1'b1, 1'b1, 32'h66666666, 8'd0, 4'd7},
    '{IA, 1'b1, 32'h0000, 32'h0,        1'b0, 1'b0, 32'h0,        8'd0, 4'd10}, // R10
    '{RD, 1'b1, 32'h2030, 32'h0,        1'b0, 1'b1, 32'h5A5A2030, 8'd0, 4'd10}, // dirty word lost
    '{RD, 1'b1, 32'h3040, 32'h0,        1'b0, 1'b1, 32'h66666666, 8'd0, 4'd10},
    '{IV, 1'b1, 32'h0820, 32'h0,        1'b0, 1'b0, 32'h0,        8'd0, 4'd9},  // absent line
    '{CL, 1'b1, 32'h5000, 32'h0,        1'b0, 1'b0, 32'h0,        8'd0, 4'd8}   // absent line
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbMode = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, respValid, respHit, memReq, memWe;
  logic [31:0] respData, memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int cycles = 0;
  logic [31:0] mem [int];
  logic gotHit;
  logic [31:0] gotData;

  set_assoc_cache i_set_assoc_cache (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .respValid(respValid),
    .respData(respData), .respHit(respHit), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a ^ 32'h5A5A0000;
  endfunction

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  // Memory model: acknowledges each word one cycle after the request
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[int'({memAddr[31:2], 2'b00})] = memWdata;
        wrCount = wrCount + 1;
      end else begin
        memRdata <= memRead({memAddr[31:2], 2'b00});
      end
    end else memAck <= 1'b0;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic wb, input logic [31:0] addr,
                      input logic [31:0] wd, output int nWr);
    int startWr;
    int waitCnt;
    @(negedge clk);
    startWr  = wrCount;
    reqValid = 1'b1;
    reqOp    = op;
    reqAddr  = addr;
    reqWdata = wd;
    wbMode   = wb;
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt  = 0;
    while (!respValid && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    gotHit  = respHit;
    gotData = respData;
    nWr     = wrCount - startWr;
    // R12: the pulse is gone one cycle later
    @(negedge clk);
    check(!respValid, "R12", "response longer than one cycle", {31'b0, respValid}, 32'h0);
  endtask

  task automatic pulseReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int nWr;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    check(reqReady == 1'b1, "R11", "reqReady in reset", {31'b0, reqReady}, 32'h1);
    check(respValid == 1'b0, "R11", "respValid in reset", {31'b0, respValid}, 32'h0);
    check(memReq == 1'b0, "R11", "memReq in reset", {31'b0, memReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].op, VECS[i].wb, VECS[i].addr, VECS[i].wdata, nWr);
      check(gotHit == VECS[i].expHit, reqName(VECS[i].rq), $sformatf("vec %0d hit", i),
            {31'b0, gotHit}, {31'b0, VECS[i].expHit});
      if (VECS[i].chkData)
        check(gotData == VECS[i].expData, reqName(VECS[i].rq), $sformatf("vec %0d data", i),
              gotData, VECS[i].expData);
      check(nWr == int'(VECS[i].expWr), reqName(VECS[i].rq), $sformatf("vec %0d memory writes", i),
            32'(nWr), {24'b0, VECS[i].expWr});
    end

    // R8: clean delivered both halves; R6: write-through reached memory
    check(memRead(32'h003C) == 32'h22222222, "R8", "cleaned last half in memory", memRead(32'h003C), 32'h22222222);
    check(memRead(32'h0020) == 32'h33333333, "R8", "cleaned first half in memory", memRead(32'h0020), 32'h33333333);
    check(memRead(32'h0028) == 32'h44444444, "R6", "write-through word", memRead(32'h0028), 32'h44444444);
    // R10: dirty word dropped by invalidate all never reached memory
    check(memRead(32'h2030) == 32'h5A5A2030, "R10", "dropped dirty word", memRead(32'h2030), 32'h5A5A2030);

    // R7: write-back store miss allocates without traffic beyond the fill
    doOp(WR, 1'b1, 32'h6060, 32'h77777777, nWr);
    check(gotHit == 1'b0, "R7", "store miss hit flag", {31'b0, gotHit}, 32'h0);
    check(nWr == 0, "R7", "store miss writes", 32'(nWr), 32'h0);
    // R1: byte bits ignored
    doOp(RD, 1'b1, 32'h6063, 32'h0, nWr);
    check(gotHit == 1'b1, "R1", "byte offset hit", {31'b0, gotHit}, 32'h1);
    check(gotData == 32'h77777777, "R1", "byte offset data", gotData, 32'h77777777);
    // R1: same word and set with another tag is a different line
    doOp(RD, 1'b1, 32'h7060, 32'h0, nWr);
    check(gotHit == 1'b0, "R1", "tag differs", {31'b0, gotHit}, 32'h0);
    check(gotData == 32'h5A5A7060, "R1", "tag differs data", gotData, 32'h5A5A7060);

    // R11: reset mid-run clears status and way counters
    doOp(RD, 1'b1, 32'h3040, 32'h0, nWr);
    check(gotHit == 1'b1, "R11", "line present before reset", {31'b0, gotHit}, 32'h1);
    pulseReset();
    doOp(RD, 1'b1, 32'h3040, 32'h0, nWr);
    check(gotHit == 1'b0, "R11", "line gone after reset", {31'b0, gotHit}, 32'h0);
    check(gotData == 32'h66666666, "R11", "refill after reset", gotData, 32'h66666666);
    // R3: counter restarted at way 0 in set 2, so the next miss takes way 1 and keeps 0x3040
    doOp(RD, 1'b1, 32'h4040, 32'h0, nWr);
    doOp(RD, 1'b1, 32'h3040, 32'h0, nWr);
    check(gotHit == 1'b1, "R3", "rotation kept way 0", {31'b0, gotHit}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule